// File: doc/BRIEF.md
# Glitch-Free Two-Level Clock Selector

This block picks one output clock from a small set of main inputs. The last main input is special: it is not a pin but the output of a plain auxiliary multiplexer, which itself picks among several further clocks. A control register holds two fields, a main code and an auxiliary code, and is written in one cycle of the control clock. A read-only one-hot status vector shows which main input is driving the output at the moment. Bit `k` of the status is set when main input `k` is the driver.

A change of main input uses a handshake. The old input's enable has to drop, clocked in its own domain, before the new input's enable may rise, clocked in the new domain. Because of this the output never shows a shortened pulse. Each enable passes through two falling-edge flops of its own clock. The status is resynchronised into the control clock. Software writes a new main code and then polls until the status equals one shifted left by that code. The auxiliary multiplexer gives no such protection. To change the auxiliary code, software first parks the main selection on a direct input, waits for the status to confirm it, and only then changes the auxiliary code.

Top module: `gf_clk_select`

## Requirements
- R1: While reset is held and right after it, the status reads 1 (main code 0) and the output follows main input 0.
- R2: Writing a main code k below NUM_MAIN-1 makes the output follow direct main input k, and the status settles to exactly 1<<k.
- R3: Main code NUM_MAIN-1 routes the output to the auxiliary input chosen by the auxiliary code (code j selects auxiliary input j), and the status settles to 1<<(NUM_MAIN-1).
- R4: The status never has more than one bit set. During a handoff it may briefly read zero.
- R5: Across all switches made under the parking rule, the output never shows a high or low pulse shorter than half the shortest input period.
- R6: If the driving input clock has stopped, a switch away from it does not complete. The status keeps the old bit and the output shows no edges. Once the clock runs again, the switch completes.
- R7: Changing the auxiliary code while the main selection is parked on a direct input has no effect on the output or the status.
- R8: Rewriting the main code that is already active leaves the status unchanged and the output period unchanged.
- R9: A write whose main code is NUM_MAIN or above leaves the main selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctlClk | input | 1 | Control clock for register writes and for status |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrMain | input | MAIN_W | Main-source code to write |
| wrAux | input | AUX_W | Auxiliary-source code to write |
| mainClkIn | input | NUM_MAIN-1 | Direct main clock inputs, codes 0 to NUM_MAIN-2 |
| auxClkIn | input | NUM_AUX | Clocks offered by the auxiliary multiplexer |
| selected | output | NUM_MAIN | One-hot status of the driving main input |
| clkOut | output | 1 | Selected clock |

## Verification
The bench builds the block with NUM_MAIN=3 and NUM_AUX=3, which gives two direct inputs and the auxiliary path at code 2, with three auxiliary clocks behind it. All five clocks have distinct periods, so a period measured on the output identifies its source. The 2-bit main field can also carry code 3, which reaches the out-of-range case. Each switch is followed by a period measurement and a status poll. A monitor flags any short output pulse. Stopping direct input 1 while it is driving shows the handoff stalling and then recovering once the clock runs again.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic [CODE_W-1:0] mainCode;
    logic [CODE_W-1:0] auxSel;
  } ctlStrobes_t;
endpackage

// File: rtl/clksel_chan.sv
`timescale 1ns/1ps
module clksel_chan #(
  parameter bit RST_ON = 1'b0
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic req,
  input  logic othersOn,
  output logic enOut
);
  logic stage1, stage2;

  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_ON;
      stage2 <= RST_ON;
    end else begin
      stage1 <= req & ~othersOn;
      stage2 <= stage1;
    end
  end

  assign enOut = stage2;
endmodule

// File: rtl/clksel_ctl.sv
`timescale 1ns/1ps
module clksel_ctl
  import clksel_pkg::*;
#(
  parameter int NUM_MAIN = 3,
  parameter int MAIN_W   = 2,
  parameter int AUX_W    = 2
) (
  input  logic                ctlClk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [MAIN_W-1:0]   wrMain,
  input  logic [AUX_W-1:0]    wrAux,
  input  logic [NUM_MAIN-1:0] enFlags,
  output ctlStrobes_t         strobes,
  output logic [NUM_MAIN-1:0] selected
);
  localparam logic [MAIN_W:0]     MAIN_LIM = NUM_MAIN[MAIN_W:0];
  localparam logic [NUM_MAIN-1:0] RST_SEL  = NUM_MAIN'(1);

  logic [MAIN_W-1:0]   mainCode;
  logic [AUX_W-1:0]    auxCode;
  logic [NUM_MAIN-1:0] syncA, syncB;

  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      mainCode <= '0;
      auxCode  <= '0;
    end else if (wrEn) begin
      if ({1'b0, wrMain} < MAIN_LIM) mainCode <= wrMain;
      auxCode <= wrAux;
    end
  end

  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      syncA <= RST_SEL;
      syncB <= RST_SEL;
    end else begin
      syncA <= enFlags;
      syncB <= syncA;
    end
  end

  always_comb begin
    strobes.mainCode = CODE_W'(mainCode);
    strobes.auxSel   = CODE_W'(auxCode);
  end

  assign selected = syncB;
endmodule

// File: rtl/clksel_path.sv
`timescale 1ns/1ps
module clksel_path
  import clksel_pkg::*;
#(
  parameter int NUM_MAIN = 3,
  parameter int NUM_AUX  = 3
) (
  input  logic                rstN,
  input  logic [NUM_MAIN-2:0] mainClkIn,
  input  logic [NUM_AUX-1:0]  auxClkIn,
  input  ctlStrobes_t         strobes,
  output logic [NUM_MAIN-1:0] enFlags,
  output logic                clkOut
);
  localparam int PAD_W = 1 << CODE_W;

  logic [PAD_W-1:0]    auxPad;
  logic                auxClk;
  logic [NUM_MAIN-1:0] srcClk, gated, othersOn, req;

  assign auxPad = PAD_W'(auxClkIn);
  assign auxClk = auxPad[strobes.auxSel];
  assign srcClk = {auxClk, mainClkIn};

  for (genvar i = 0; i < NUM_MAIN; i++) begin : g_chan
    assign req[i]      = (strobes.mainCode == CODE_W'(i));
    assign othersOn[i] = |(enFlags & ~(NUM_MAIN'(1) << i));

    clksel_chan #(.RST_ON(i == 0)) u_chan (
      .clkIn   (srcClk[i]),
      .rstN    (rstN),
      .req     (req[i]),
      .othersOn(othersOn[i]),
      .enOut   (enFlags[i])
    );

    assign gated[i] = srcClk[i] & enFlags[i];
  end

  assign clkOut = |gated;
endmodule

// File: rtl/gf_clk_select.sv
`timescale 1ns/1ps
module gf_clk_select
  import clksel_pkg::*;
#(
  parameter int NUM_MAIN = 3,
  parameter int NUM_AUX  = 3,
  localparam int MAIN_W  = (NUM_MAIN > 2) ? $clog2(NUM_MAIN) : 1,
  localparam int AUX_W   = (NUM_AUX > 2) ? $clog2(NUM_AUX) : 1
) (
  input  logic                ctlClk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [MAIN_W-1:0]   wrMain,
  input  logic [AUX_W-1:0]    wrAux,
  input  logic [NUM_MAIN-2:0] mainClkIn,
  input  logic [NUM_AUX-1:0]  auxClkIn,
  output logic [NUM_MAIN-1:0] selected,
  output logic                clkOut
);
  ctlStrobes_t         strobes;
  logic [NUM_MAIN-1:0] enFlags;
  logic [NUM_MAIN-1:0] reqNow;

  assign reqNow = NUM_MAIN'(1) << strobes.mainCode;

  clksel_ctl #(.NUM_MAIN(NUM_MAIN), .MAIN_W(MAIN_W), .AUX_W(AUX_W)) u_ctl (
    .ctlClk  (ctlClk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrMain  (wrMain),
    .wrAux   (wrAux),
    .enFlags (enFlags),
    .strobes (strobes),
    .selected(selected)
  );

  clksel_path #(.NUM_MAIN(NUM_MAIN), .NUM_AUX(NUM_AUX)) u_path (
    .rstN     (rstN),
    .mainClkIn(mainClkIn),
    .auxClkIn (auxClkIn),
    .strobes  (strobes),
    .enFlags  (enFlags),
    .clkOut   (clkOut)
  );
endmodule

// File: rtl/clksel_chk.sv
`timescale 1ns/1ps
module clksel_chk #(
  parameter int NUM_MAIN = 3,
  parameter int MAIN_W   = 2
) (
  input logic                ctlClk,
  input logic                rstN,
  input logic                wrEn,
  input logic [MAIN_W-1:0]   wrMain,
  input logic [NUM_MAIN-1:0] selected,
  input logic [NUM_MAIN-1:0] reqNow
);
  AST_RESET_STATUS: assert property (@(posedge ctlClk) disable iff (!rstN)
    $rose(rstN) |-> selected == NUM_MAIN'(1)); // R1

  AST_STATUS_ONEHOT0: assert property (@(posedge ctlClk) disable iff (!rstN)
    $onehot0(selected)); // R4

  AST_ARRIVE_AT_REQ: assert property (@(posedge ctlClk) disable iff (!rstN)
    (selected != '0 && selected != $past(selected)) |-> selected == reqNow); // R2

  AST_SAME_CODE_STABLE: assert property (@(posedge ctlClk) disable iff (!rstN)
    (wrEn && selected == reqNow && selected == (NUM_MAIN'(1) << wrMain))
      |=> selected == $past(selected)); // R8
endmodule

bind gf_clk_select clksel_chk #(.NUM_MAIN(NUM_MAIN), .MAIN_W(MAIN_W)) u_chk (
  .ctlClk  (ctlClk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrMain  (wrMain),
  .selected(selected),
  .reqNow  (reqNow)
);

// File: tb/sim_gf_clk_select.sv
`timescale 1ns/1ps
module sim_gf_clk_select;
  localparam int NM = 3;
  localparam int NA = 3;
  localparam int AUXC = NM - 1;
  // vectors: main code, aux code, expected output period in ns
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{1, 0, 14}, '{2, 0, 6}, '{2, 2, 22}, '{0, 2, 10},
    '{2, 1, 18}, '{1, 1, 14}, '{2, 0, 6}
  };

  logic ctlClk = 1'b0;
  always #4 ctlClk = ~ctlClk;

  logic m0 = 0, m1 = 0, a0 = 0, a1 = 0, a2 = 0;
  bit stop1 = 0;
  always #5 m0 = ~m0;
  always #7 m1 = stop1 ? 1'b0 : ~m1;
  always #3 a0 = ~a0;
  always #9 a1 = ~a1;
  always #11 a2 = ~a2;

  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrMain = '0;
  logic [1:0] wrAux = '0;
  logic [NM-1:0] selected;
  logic clkOut;

  gf_clk_select #(.NUM_MAIN(NM), .NUM_AUX(NA)) u0 (
    .ctlClk(ctlClk), .rstN(rstN), .wrEn(wrEn), .wrMain(wrMain), .wrAux(wrAux),
    .mainClkIn({m1, m0}), .auxClkIn({a2, a1, a0}),
    .selected(selected), .clkOut(clkOut)
  );

  int nChk = 0, nFail = 0;
  int curMain = 0, curAux = 0;
  bit done = 0, monOn = 0;
  realtime lastEdge = 0, prevEdge = 0, lastTog = 0;
  int edgeCnt = 0, glitches = 0, multiHot = 0;

  always @(posedge clkOut) begin
    prevEdge = lastEdge;
    lastEdge = $realtime;
    edgeCnt++;
  end

  always @(clkOut) begin
    if (monOn && ($realtime - lastTog) < 2.9) glitches++;
    lastTog = $realtime;
  end

  always @(negedge ctlClk) if (rstN && $countones(selected) > 1) multiHot++;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(int m, int a);
    @(negedge ctlClk);
    wrEn = 1'b1; wrMain = 2'(m); wrAux = 2'(a);
    @(negedge ctlClk);
    wrEn = 1'b0;
  endtask

  task automatic pollSel(int exp, output bit ok);
    ok = 0;
    for (int k = 0; k < 400 && !ok; k++) begin
      @(negedge ctlClk);
      if (int'(selected) == exp) ok = 1;
    end
  endtask

  task automatic measure(output int perPs, output int cnt);
    int c0;
    c0 = edgeCnt;
    #300;
    cnt = edgeCnt - c0;
    perPs = int'((lastEdge - prevEdge) * 1000.0);
  endtask

  task automatic checkPeriod(string req, int expNs);
    int p, c;
    measure(p, c);
    check(c > 5 && p > expNs * 1000 - 5 && p < expNs * 1000 + 5, req, "period ps", p, expNs * 1000);
  endtask

  // follows the parking rule before any aux change
  task automatic goTo(int m, int a, string req);
    bit ok;
    if (m == AUXC && a != curAux) begin
      if (curMain == AUXC) begin
        writeReg(0, curAux);
        pollSel(1, ok);
        curMain = 0;
      end
      writeReg(curMain, a);
      curAux = a;
    end
    writeReg(m, curAux);
    pollSel(1 << m, ok);
    curMain = m;
    check(ok, req, "status", int'(selected), 1 << m);
  endtask

  initial begin
    #500000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int p, c, bad;
    bit ok;
    repeat (10) @(negedge ctlClk);
    check(selected == 3'b001, "R1", "status in reset", int'(selected), 1);
    rstN = 1'b1;
    @(negedge ctlClk);
    check(selected == 3'b001, "R1", "status after reset", int'(selected), 1);
    checkPeriod("R1", 10);
    monOn = 1;

    for (int v = 0; v < NV; v++) begin
      goTo(VEC[v][0], VEC[v][1], VEC[v][0] == AUXC ? "R3" : "R2");
      checkPeriod(VEC[v][0] == AUXC ? "R3" : "R2", VEC[v][2]);
    end

    // R7: aux change while parked on direct input 0
    goTo(0, curAux, "R7");
    writeReg(0, (curAux + 1) % NA);
    curAux = (curAux + 1) % NA;
    repeat (50) @(negedge ctlClk);
    check(selected == 3'b001, "R7", "status", int'(selected), 1);
    checkPeriod("R7", 10);

    // R9: out-of-range main code
    writeReg(3, curAux);
    repeat (50) @(negedge ctlClk);
    check(selected == 3'b001, "R9", "status", int'(selected), 1);
    checkPeriod("R9", 10);

    // R8: rewrite the active code
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      writeReg(0, curAux);
      repeat (10) begin
        @(negedge ctlClk);
        if (selected != 3'b001) bad++;
      end
    end
    check(bad == 0, "R8", "status deviations", bad, 0);
    checkPeriod("R8", 10);

    // R6: stalled handoff from a stopped clock
    goTo(1, curAux, "R6");
    stop1 = 1;
    #50;
    c = edgeCnt;
    writeReg(0, curAux);
    repeat (300) @(negedge ctlClk);
    check(selected == 3'b010, "R6", "status while stopped", int'(selected), 2);
    check(edgeCnt == c, "R6", "edges while stopped", edgeCnt - c, 0);
    stop1 = 0;
    pollSel(1, ok);
    curMain = 0;
    check(ok, "R6", "status after restart", int'(selected), 1);
    checkPeriod("R6", 10);

    check(multiHot == 0, "R4", "multi-hot samples", multiHot, 0);
    check(glitches == 0, "R5", "short pulses", glitches, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule